// File: doc/BRIEF.md
# Shifter Operand Generator with Carry

This block forms the second operand of a 32-bit integer datapath. It takes a register value and shifts or rotates it by an amount that comes either from a register (an 8-bit count) or from a 5-bit field in the instruction word. Four shift kinds are supported. Alongside the operand it returns a shifter carry-out, which the flag logic uses for logical operations. A separate mode builds an operand from an 8-bit constant rotated by an even amount.

The block is purely combinational and sits between the register-read stage and the ALU. Several count values have special meanings. An immediate count of zero stands for a shift by 32 on right shifts and for a one-bit rotate through carry on rotates. Register counts of 32 or more give defined results and carries.

Top module: `shift_operand_gen`

## Requirements
- R1: Shift kind encoding on `kind_i` is 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. With `amt_from_reg_i`=1 and `reg_amt_i`=0, the operand passes through unchanged and `carry_o` equals `carry_i`, for every kind.
- R2: For a count n in 1..31, the result is the operand shifted or rotated by n. Logical shifts fill with zeros. Arithmetic right shifts fill with operand bit 31.
- R3: For a count n in 1..31, `carry_o` is the last bit shifted out: operand bit 32-n for a left shift, and operand bit n-1 for right shifts and rotates.
- R4: For a register-count left shift, a count of 32 gives result 0 with carry equal to operand bit 0. A count above 32 gives result 0 with carry 0.
- R5: For a register-count logical right shift, a count of 32 gives result 0 with carry equal to operand bit 31. A count above 32 gives result 0 with carry 0.
- R6: For a register-count arithmetic right shift with a count of 32 or more, every result bit is operand bit 31, and the carry is operand bit 31.
- R7: For a register-count rotate, the rotate uses the count modulo 32. A nonzero count whose low five bits are zero returns the operand unchanged, with carry equal to operand bit 31.
- R8: For an immediate left shift with a count field of 0, the operand passes through and `carry_o` equals `carry_i`.
- R9: For an immediate logical or arithmetic right shift, a count field of 0 means a shift by 32. The logical form gives 0 and the arithmetic form gives sign fill. In both cases the carry is operand bit 31.
- R10: For an immediate rotate with a count field of 0, the block performs a rotate right by one through carry. The result is {`carry_i`, operand[31:1]} and the carry is operand bit 0.
- R11: With `rot_imm_mode_i`=1, the result is `const_i` (zero-extended) rotated right by 2×`rot_i`. The carry equals `carry_i` when `rot_i`=0 and equals result bit 31 otherwise.
- R12: With `rot_imm_mode_i`=1, the outputs do not depend on `opnd_i`, `kind_i`, `amt_from_reg_i`, `reg_amt_i` or `imm_amt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Register value to shift or rotate |
| reg_amt_i | input | 8 | Shift count taken from a register |
| imm_amt_i | input | 5 | Shift count field from the instruction |
| kind_i | input | 2 | Shift kind (encoding in R1) |
| amt_from_reg_i | input | 1 | 1 selects `reg_amt_i`, 0 selects `imm_amt_i` |
| carry_i | input | 1 | Current carry flag |
| rot_imm_mode_i | input | 1 | 1 selects the rotated-constant operand |
| const_i | input | 8 | Constant for rotated-constant mode |
| rot_i | input | 4 | Rotate field; the constant rotates by twice this value |
| result_o | output | 32 | Generated operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
On every evaluation, the embedded assertions check these behaviours:
- the register-count-zero pass-through;
- sign fill for large arithmetic counts;
- the rotate-through-carry bit placement;
- the unrotated constant case;
- bit-count preservation by the rotator;
- the rule that a normal shift never carries a zero count.

The exact bit positions of results and carries for each count from 1 to 31, the boundary at exactly 32 against larger counts, and the independence of the rotated-constant mode from the shift inputs can only be shown by the bench. It sweeps every register count from 0 to 255 and every immediate field value, for each kind, over patterned and random operands.

// File: rtl/shift_operand_pkg.sv
package shift_operand_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  // Case classes produced by the count decoder
  typedef enum logic [2:0] {
    CL_PASS   = 3'd0,  // operand unchanged, incoming carry kept
    CL_NORM   = 3'd1,  // ordinary shift/rotate by 1..W-1
    CL_FULL   = 3'd2,  // shift by exactly W
    CL_BEYOND = 3'd3,  // shift by more than W
    CL_RRX    = 3'd4,  // one-bit rotate through carry
    CL_RORW   = 3'd5   // nonzero rotate that is a multiple of W
  } shift_class_e;

endpackage

// File: rtl/shift_rotator.sv
module shift_rotator #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [0:AW];

  assign stg[0] = din;

  generate
    for (genvar s = 0; s < AW; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
    end
  endgenerate

  assign dout = stg[AW];

  // Rotation never creates or destroys set bits
  always_comb begin
    assert_rot_keeps_ones_R2: assert ($countones(dout) == $countones(din))
      else $error("rotator changed the population count");
  end

endmodule

// File: rtl/shift_count_decode.sv
module shift_count_decode
  import shift_operand_pkg::*;
#(
  parameter int W   = 32,
  parameter int RAW = 8,
  localparam int AW = $clog2(W)
) (
  input  shift_kind_e   kind,
  input  logic          from_reg,
  input  logic [RAW-1:0] reg_amt,
  input  logic [AW-1:0] imm_amt,
  output shift_class_e  cls,
  output logic [AW-1:0] amt_n,
  output logic [AW-1:0] rot_amt
);

  always_comb begin
    cls   = CL_NORM;
    amt_n = '0;
    if (from_reg) begin
      amt_n = reg_amt[AW-1:0];
      if (reg_amt == '0) begin
        cls = CL_PASS;
      end else if (kind == SK_ROR) begin
        cls = (reg_amt[AW-1:0] == '0) ? CL_RORW : CL_NORM;
      end else if (int'(reg_amt) < W) begin
        cls = CL_NORM;
      end else if (int'(reg_amt) == W) begin
        cls = CL_FULL;
      end else begin
        cls = CL_BEYOND;
      end
    end else begin
      amt_n = imm_amt;
      if (imm_amt == '0) begin
        unique case (kind)
          SK_LSL:  cls = CL_PASS;
          SK_LSR:  cls = CL_FULL;
          SK_ASR:  cls = CL_FULL;
          default: cls = CL_RRX;
        endcase
      end else begin
        cls = CL_NORM;
      end
    end
  end

  // A left shift by n is a right rotate by W-n (mod W)
  assign rot_amt = (kind == SK_LSL) ? (AW'(0) - amt_n) : amt_n;

  always_comb begin
    if (cls == CL_NORM) begin
      assert_norm_nonzero_R2: assert (amt_n != '0)
        else $error("normal shift decoded with a zero count");
    end
  end

endmodule

// File: rtl/rot_const_unit.sv
module rot_const_unit #(
  parameter int W  = 32,
  parameter int CW = 8,
  parameter int RW = 4,
  localparam int AW = $clog2(W)
) (
  input  logic [CW-1:0] konst,
  input  logic [RW-1:0] rot,
  input  logic          carry_in,
  output logic [W-1:0]  value,
  output logic          carry_out
);

  logic [AW-1:0] amt2;

  assign amt2 = AW'({rot, 1'b0});

  shift_rotator #(.W(W)) u_rot (
    .din  ({{(W-CW){1'b0}}, konst}),
    .amt  (amt2),
    .dout (value)
  );

  assign carry_out = (rot == '0) ? carry_in : value[W-1];

  always_comb begin
    if (rot == '0) begin
      assert_const_unrotated_R11: assert (value == {{(W-CW){1'b0}}, konst} && carry_out == carry_in)
        else $error("unrotated constant altered");
    end
  end

endmodule

// File: rtl/shift_operand_gen.sv
module shift_operand_gen
  import shift_operand_pkg::*;
#(
  parameter int W   = 32,
  parameter int RAW = 8,
  parameter int CW  = 8,
  parameter int RW  = 4,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]   opnd_i,
  input  logic [RAW-1:0] reg_amt_i,
  input  logic [AW-1:0]  imm_amt_i,
  input  logic [1:0]     kind_i,
  input  logic           amt_from_reg_i,
  input  logic           carry_i,
  input  logic           rot_imm_mode_i,
  input  logic [CW-1:0]  const_i,
  input  logic [RW-1:0]  rot_i,
  output logic [W-1:0]   result_o,
  output logic           carry_o
);

  shift_kind_e  kind;
  shift_class_e cls;
  logic [AW-1:0] amt_n;
  logic [AW-1:0] rot_amt;
  logic [W-1:0]  rotated;
  logic [W-1:0]  lo_mask;
  logic [W-1:0]  hi_mask;
  logic [W-1:0]  sign_fill;
  logic [W-1:0]  sh_res;
  logic          sh_carry;
  logic [W-1:0]  k_res;
  logic          k_carry;

  assign kind = shift_kind_e'(kind_i);

  shift_count_decode #(.W(W), .RAW(RAW)) u_dec (
    .kind     (kind),
    .from_reg (amt_from_reg_i),
    .reg_amt  (reg_amt_i),
    .imm_amt  (imm_amt_i),
    .cls      (cls),
    .amt_n    (amt_n),
    .rot_amt  (rot_amt)
  );

  shift_rotator #(.W(W)) u_rot (
    .din  (opnd_i),
    .amt  (rot_amt),
    .dout (rotated)
  );

  rot_const_unit #(.W(W), .CW(CW), .RW(RW)) u_const (
    .konst     (const_i),
    .rot       (rot_i),
    .carry_in  (carry_i),
    .value     (k_res),
    .carry_out (k_carry)
  );

  assign lo_mask   = ~({W{1'b1}} << amt_n);
  assign hi_mask   = ~({W{1'b1}} >> amt_n);
  assign sign_fill = {W{opnd_i[W-1]}};

  always_comb begin
    sh_res   = opnd_i;
    sh_carry = carry_i;
    unique case (cls)
      CL_PASS: begin
        sh_res   = opnd_i;
        sh_carry = carry_i;
      end
      CL_NORM: begin
        unique case (kind)
          SK_LSL: begin
            sh_res   = rotated & ~lo_mask;
            sh_carry = rotated[0];
          end
          SK_LSR: begin
            sh_res   = rotated & ~hi_mask;
            sh_carry = rotated[W-1];
          end
          SK_ASR: begin
            sh_res   = (rotated & ~hi_mask) | (sign_fill & hi_mask);
            sh_carry = rotated[W-1];
          end
          default: begin
            sh_res   = rotated;
            sh_carry = rotated[W-1];
          end
        endcase
      end
      CL_FULL: begin
        unique case (kind)
          SK_LSL: begin
            sh_res   = '0;
            sh_carry = opnd_i[0];
          end
          SK_ASR: begin
            sh_res   = sign_fill;
            sh_carry = opnd_i[W-1];
          end
          default: begin
            sh_res   = '0;
            sh_carry = opnd_i[W-1];
          end
        endcase
      end
      CL_BEYOND: begin
        if (kind == SK_ASR) begin
          sh_res   = sign_fill;
          sh_carry = opnd_i[W-1];
        end else begin
          sh_res   = '0;
          sh_carry = 1'b0;
        end
      end
      CL_RRX: begin
        sh_res   = {carry_i, opnd_i[W-1:1]};
        sh_carry = opnd_i[0];
      end
      default: begin
        sh_res   = opnd_i;
        sh_carry = opnd_i[W-1];
      end
    endcase
  end

  assign result_o = rot_imm_mode_i ? k_res   : sh_res;
  assign carry_o  = rot_imm_mode_i ? k_carry : sh_carry;

  always_comb begin
    if (!rot_imm_mode_i && amt_from_reg_i && reg_amt_i == '0) begin
      assert_reg_zero_pass_R1: assert (result_o == opnd_i && carry_o == carry_i)
        else $error("zero register count did not pass through");
    end
    if (!rot_imm_mode_i && amt_from_reg_i && kind_i == 2'b10 && int'(reg_amt_i) >= W) begin
      assert_asr_large_fill_R6: assert (result_o == {W{opnd_i[W-1]}} && carry_o == opnd_i[W-1])
        else $error("large arithmetic shift not sign-filled");
    end
    if (!rot_imm_mode_i && !amt_from_reg_i && kind_i == 2'b11 && imm_amt_i == '0) begin
      assert_rrx_bits_R10: assert (result_o[W-2:0] == opnd_i[W-1:1] && result_o[W-1] == carry_i
                                   && carry_o == opnd_i[0])
        else $error("rotate through carry misplaced bits");
    end
    if (rot_imm_mode_i) begin
      assert_const_popcount_R12: assert ($countones(result_o) == $countones(const_i))
        else $error("rotated constant bit count differs from constant");
    end
  end

endmodule

// File: tb/test_shift_operand_gen.sv
`timescale 1ns/1ps
module test_shift_operand_gen;

  logic        clk;
  logic        rst_n;
  logic [31:0] opnd;
  logic [7:0]  reg_amt;
  logic [4:0]  imm_amt;
  logic [1:0]  kind;
  logic        from_reg;
  logic        cin;
  logic        rimode;
  logic [7:0]  konst;
  logic [3:0]  rot;
  logic [31:0] res;
  logic        cout;

  int checks;
  int fails;
  int cycles;
  bit done;

  shift_operand_gen i_shift_operand_gen (
    .opnd_i         (opnd),
    .reg_amt_i      (reg_amt),
    .imm_amt_i      (imm_amt),
    .kind_i         (kind),
    .amt_from_reg_i (from_reg),
    .carry_i        (cin),
    .rot_imm_mode_i (rimode),
    .const_i        (konst),
    .rot_i          (rot),
    .result_o       (res),
    .carry_o        (cout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] ror32(input logic [31:0] x, input int m);
    if (m == 0) return x;
    return (x >> m) | (x << (32 - m));
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [1:0] k, input bit fr, input int ra, input int ia,
                       input logic c, input logic [31:0] x,
                       output logic [31:0] er, output logic ec, output string tag);
    int n;
    n = fr ? ra : ia;
    er = x; ec = c; tag = "R2";
    if (fr && n == 0) begin
      er = x; ec = c; tag = "R1";
    end else if (!fr && n == 0) begin
      case (k)
        2'b00: begin er = x; ec = c; tag = "R8"; end
        2'b01: begin er = 32'h0; ec = x[31]; tag = "R9"; end
        2'b10: begin er = {32{x[31]}}; ec = x[31]; tag = "R9"; end
        default: begin er = {c, x[31:1]}; ec = x[0]; tag = "R10"; end
      endcase
    end else if (k == 2'b11) begin
      if (n % 32 == 0) begin
        er = x; ec = x[31]; tag = "R7";
      end else begin
        er = ror32(x, n % 32); ec = x[(n % 32) - 1];
        tag = (n >= 32) ? "R7" : "R3";
      end
    end else if (n < 32) begin
      tag = "R3";
      case (k)
        2'b00: begin er = x << n; ec = x[32 - n]; end
        2'b01: begin er = x >> n; ec = x[n - 1]; end
        default: begin er = 32'($signed(x) >>> n); ec = x[n - 1]; end
      endcase
    end else begin
      case (k)
        2'b00: begin er = 32'h0; ec = (n == 32) ? x[0] : 1'b0; tag = "R4"; end
        2'b01: begin er = 32'h0; ec = (n == 32) ? x[31] : 1'b0; tag = "R5"; end
        default: begin er = {32{x[31]}}; ec = x[31]; tag = "R6"; end
      endcase
    end
  endtask

  task automatic check(input logic [31:0] er, input logic ec, input string tag);
    checks = checks + 1;
    if (res !== er || cout !== ec) begin
      fails = fails + 1;
      $display("FAIL %s kind=%0d reg=%0d ramt=%0d iamt=%0d x=%h cin=%0d: got %h/%0d expected %h/%0d",
               tag, kind, from_reg, reg_amt, imm_amt, opnd, cin, res, cout, er, ec);
    end
  endtask

  task automatic apply_shift(input logic [1:0] k, input bit fr, input int ra, input int ia,
                             input logic c, input logic [31:0] x);
    logic [31:0] er;
    logic ec;
    string tag;
    @(posedge clk);
    rimode = 1'b0; kind = k; from_reg = fr; reg_amt = 8'(ra); imm_amt = 5'(ia);
    cin = c; opnd = x;
    @(negedge clk);
    model(k, fr, ra, ia, c, x, er, ec, tag);
    check(er, ec, tag);
  endtask

  // R1 idle state: all zero inputs give zero operand and carry follows carry_i
  task automatic t_idle();
    @(posedge clk);
    rimode = 1'b0; kind = 2'b00; from_reg = 1'b1; reg_amt = 8'd0; imm_amt = 5'd0;
    cin = 1'b0; opnd = 32'h0; konst = 8'h0; rot = 4'h0;
    @(negedge clk);
    check(32'h0, 1'b0, "R1");
  endtask

  // R1 R2 R3 R4 R5 R6 R7: every register count for every kind
  task automatic t_reg_sweep(input logic [31:0] x, input logic c);
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 256; a++)
        apply_shift(2'(k), 1'b1, a, 0, c, x);
  endtask

  // R2 R3 R8 R9 R10: every immediate field value for every kind
  task automatic t_imm_sweep(input logic [31:0] x, input logic c);
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        apply_shift(2'(k), 1'b0, 0, a, c, x);
  endtask

  // R11: rotated constant, all rotate fields
  task automatic t_rot_const(input logic [7:0] kv, input logic c);
    logic [31:0] er;
    logic ec;
    for (int r = 0; r < 16; r++) begin
      @(posedge clk);
      rimode = 1'b1; konst = kv; rot = 4'(r); cin = c;
      @(negedge clk);
      er = ror32({24'h0, kv}, 2 * r);
      ec = (r == 0) ? c : er[31];
      check(er, ec, "R11");
    end
  endtask

  // R12: shift inputs are ignored in rotated-constant mode
  task automatic t_const_ignores();
    logic [31:0] er;
    er = ror32(32'h0000_00A5, 6);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      rimode = 1'b1; konst = 8'hA5; rot = 4'd3; cin = 1'b0;
      opnd = $urandom; kind = 2'($urandom); from_reg = 1'($urandom);
      reg_amt = 8'($urandom); imm_amt = 5'($urandom);
      @(negedge clk);
      check(er, er[31], "R12");
    end
  endtask

  initial begin
    checks = 0; fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    opnd = '0; reg_amt = '0; imm_amt = '0; kind = '0; from_reg = 1'b0;
    cin = 1'b0; rimode = 1'b0; konst = '0; rot = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_reg_sweep(32'h8000_0001, 1'b0);
    t_reg_sweep(32'h7FFF_FFFE, 1'b1);
    t_reg_sweep(32'hC3A5_5A3C, 1'b1);
    t_reg_sweep($urandom, 1'b0);
    t_imm_sweep(32'h8000_0001, 1'b1);
    t_imm_sweep(32'h1234_5678, 1'b0);
    t_imm_sweep(32'hFEDC_BA98, 1'b1);
    for (int i = 0; i < 4; i++) t_imm_sweep($urandom, 1'($urandom));
    t_rot_const(8'hFF, 1'b1);
    t_rot_const(8'h81, 1'b0);
    t_rot_const(8'h01, 1'b1);
    t_const_ignores();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule